// File: doc/BRIEF.md
# Chainable Bit-Slice ALU

This block is a purely combinational N-bit arithmetic and logic unit. It is built from identical one-bit slices joined by a ripple carry. Each slice first conditions its two operand bits. A separate enable forces each operand to zero, and an invert control can complement the A bit after its enable is applied. The conditioned bits then feed four function units: AND, OR, complement of B, and a full adder. A two-bit function select picks which unit drives the result bit.

Because operand conditioning happens before the function units, the same four functions also give other results. Disabling both operands gives constants. Inverting A and setting the least significant carry-in gives B minus A. Disabling B and doing the same gives the negation of A. The top level returns the N-bit result, the carry out of the most significant slice, and a signed-overflow flag that is valid in add mode.

Top module: `alu_slice_chain`

## Requirements
- R1: With fsel_i = 2'b00 (fsel_i[0] is F0, fsel_i[1] is F1), result_o is the bitwise AND of the conditioned A and conditioned B.
- R2: With fsel_i = 2'b01 (F0=1, F1=0), result_o is the bitwise complement of the conditioned B, where a disabled B (en_b_i=0) reads as all zeros, giving all ones.
- R3: With fsel_i = 2'b10 (F0=0, F1=1), result_o is the bitwise OR of the conditioned A and conditioned B.
- R4: With fsel_i = 2'b11, {cout_o, result_o} equals conditioned A plus conditioned B plus cin_i, taken modulo 2^(N+1).
- R5: A disabled operand is forced to zero before inversion. With en_a_i=0 and inv_a_i=1, the conditioned A is all ones.
- R6: cout_o is 0 whenever fsel_i is not 2'b11.
- R7: With fsel_i=2'b11, both enables high, inv_a_i=1 and cin_i=1, result_o equals B minus A modulo 2^N.
- R8: ovf_o is 1 only when fsel_i=2'b11 and the carry into the most significant slice differs from the carry out of it. This is two's-complement overflow of the add. ovf_o is 0 in every other mode.
- R9: Unsigned addition wraps. At 4 bits, 1111 plus 0001 with cin_i=0 gives 0000 with cout_o=1.
- R10: At 8 bits, 98 plus 35 gives 8'b10000101 with ovf_o=1 and cout_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| fsel_i | input | 2 | Function select: bit 0 is F0, bit 1 is F1 |
| en_a_i | input | 1 | Operand A enable; 0 forces A to zero |
| en_b_i | input | 1 | Operand B enable; 0 forces B to zero |
| inv_a_i | input | 1 | Complement conditioned A after its enable |
| cin_i | input | 1 | Carry into the least significant slice |
| result_o | output | WIDTH | Result bits |
| cout_o | output | 1 | Carry out of the most significant slice |
| ovf_o | output | 1 | Signed overflow, valid in add mode |

## Verification
The block holds no state, so any fault in a slice, in its conditioning or in the carry chain shows at the ports in the same evaluation as the stimulus. The fault can be hidden only when the selected unit masks the faulty bit. Sweeping every operand pair, select, enable, invert and carry-in value at 4 bits uncovers each broken slice or carry link. A wrong carry link shows as a wrong sum bit or cout_o. A wrong overflow tap shows as ovf_o asserting in a non-add mode or failing on same-sign sums.

// File: rtl/alu_pkg.sv
package alu_pkg;
  // Function select, bit 0 is F0 and bit 1 is F1.
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_NOTB = 2'b01,
    FN_OR   = 2'b10,
    FN_ADD  = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             en_a_i,
  input  logic             en_b_i,
  input  logic             inv_a_i,
  output logic [WIDTH-1:0] a_c_o,
  output logic [WIDTH-1:0] b_c_o
);
  // Enable gating is applied first, inversion of A afterwards.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      a_c_o[i] = (a_i[i] & en_a_i) ^ inv_a_i;
      b_c_o[i] = b_i[i] & en_b_i;
    end
  end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    cin_i,
  input  alu_fn_e fn_i,
  output logic    res_o,
  output logic    cout_o
);
  logic u_and, u_or, u_notb, u_sum, u_carry;

  always_comb begin
    u_and   = a_i & b_i;
    u_or    = a_i | b_i;
    u_notb  = ~b_i;
    u_sum   = a_i ^ b_i ^ cin_i;
    u_carry = (a_i & b_i) | (cin_i & (a_i ^ b_i));
  end

  always_comb begin
    res_o  = 1'b0;
    cout_o = 1'b0;
    unique case (fn_i)
      FN_AND:  res_o = u_and;
      FN_NOTB: res_o = u_notb;
      FN_OR:   res_o = u_or;
      FN_ADD: begin
        res_o  = u_sum;
        cout_o = u_carry;
      end
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_ovf_detect.sv
module alu_ovf_detect
  import alu_pkg::*;
(
  input  alu_fn_e fn_i,
  input  logic    c_msb_in_i,
  input  logic    c_msb_out_i,
  output logic    ovf_o
);
  always_comb ovf_o = (fn_i == FN_ADD) & (c_msb_in_i ^ c_msb_out_i);
endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       fsel_i,
  input  logic             en_a_i,
  input  logic             en_b_i,
  input  logic             inv_a_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] result_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  alu_fn_e          fn;
  logic [WIDTH-1:0] a_c, b_c;
  logic [WIDTH:0]   carry;

  always_comb fn = alu_fn_e'(fsel_i);

  alu_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .a_i     (a_i),
    .b_i     (b_i),
    .en_a_i  (en_a_i),
    .en_b_i  (en_b_i),
    .inv_a_i (inv_a_i),
    .a_c_o   (a_c),
    .b_c_o   (b_c)
  );

  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .a_i    (a_c[i]),
      .b_i    (b_c[i]),
      .cin_i  (carry[i]),
      .fn_i   (fn),
      .res_o  (result_o[i]),
      .cout_o (carry[i+1])
    );
  end

  assign cout_o = carry[WIDTH];

  alu_ovf_detect u_ovf (
    .fn_i        (fn),
    .c_msb_in_i  (carry[MSB]),
    .c_msb_out_i (carry[WIDTH]),
    .ovf_o       (ovf_o)
  );
endmodule

// File: rtl/alu_slice_chain_chk.sv
module alu_slice_chain_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       fsel_i,
  input logic             en_a_i,
  input logic             en_b_i,
  input logic             inv_a_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] result_o,
  input logic             cout_o,
  input logic             ovf_o
);
  logic [WIDTH-1:0] ac, bc;
  logic [WIDTH:0]   sum_ref;
  logic             same_sign_in, sign_flip;

  always_comb begin
    ac = en_a_i ? a_i : '0;
    if (inv_a_i) ac = ~ac;
    bc = en_b_i ? b_i : '0;
    sum_ref = {1'b0, ac} + {1'b0, bc} + {{WIDTH{1'b0}}, cin_i};
    same_sign_in = (ac[WIDTH-1] == bc[WIDTH-1]);
    sign_flip    = (sum_ref[WIDTH-1] != ac[WIDTH-1]);

    // R1
    r1_and_unit_chk: assert (fsel_i != 2'b00 || result_o == (ac & bc));
    // R2
    r2_notb_unit_chk: assert (fsel_i != 2'b01 || result_o == ~bc);
    // R3
    r3_or_unit_chk: assert (fsel_i != 2'b10 || result_o == (ac | bc));
    // R4
    r4_add_unit_chk: assert (fsel_i != 2'b11 || {cout_o, result_o} == sum_ref);
    // R6
    r6_cout_idle_chk: assert (fsel_i == 2'b11 || !cout_o);
    // R8
    r8_ovf_chk: assert (ovf_o == (fsel_i == 2'b11 && same_sign_in && sign_flip));
  end
endmodule

bind alu_slice_chain alu_slice_chain_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .fsel_i   (fsel_i),
  .en_a_i   (en_a_i),
  .en_b_i   (en_b_i),
  .inv_a_i  (inv_a_i),
  .cin_i    (cin_i),
  .result_o (result_o),
  .cout_o   (cout_o),
  .ovf_o    (ovf_o)
);

// File: tb/alu_slice_chain_tb.sv
module alu_slice_chain_tb;
  localparam int W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  logic [W-1:0] a, b, res;
  logic [1:0]   fsel;
  logic         ena, enb, inva, cin, cout, ovf;

  logic [7:0] a8, b8, res8;
  logic [1:0] fsel8;
  logic       cout8, ovf8;

  alu_slice_chain #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .fsel_i(fsel), .en_a_i(ena), .en_b_i(enb),
    .inv_a_i(inva), .cin_i(cin), .result_o(res), .cout_o(cout), .ovf_o(ovf)
  );

  alu_slice_chain #(.WIDTH(8)) u_dut8 (
    .a_i(a8), .b_i(b8), .fsel_i(fsel8), .en_a_i(1'b1), .en_b_i(1'b1),
    .inv_a_i(1'b0), .cin_i(1'b0), .result_o(res8), .cout_o(cout8), .ovf_o(ovf8)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Pack {ovf, cout, result} for one comparison.
  function automatic int pack(input logic o, input logic c, input logic [W-1:0] r);
    return {o, c, r};
  endfunction

  task automatic drive(input int av, input int bv, input int f, input int ea,
                       input int eb, input int ia, input int ci);
    @(posedge clk);
    a = W'(av); b = W'(bv); fsel = 2'(f);
    ena = 1'(ea); enb = 1'(eb); inva = 1'(ia); cin = 1'(ci);
    @(negedge clk);
  endtask

  initial begin
    a = '0; b = '0; fsel = 2'b00; ena = 1'b0; enb = 1'b0; inva = 1'b0; cin = 1'b0;
    a8 = '0; b8 = '0; fsel8 = 2'b00;
    @(negedge clk);
    // Idle inputs: AND of zeros, no carry, no overflow (R1, R6, R8).
    check("R1 idle", pack(ovf, cout, res), 0);

    // Exhaustive sweep at 4 bits.
    for (int f = 0; f < 4; f++)
      for (int ea = 0; ea < 2; ea++)
        for (int eb = 0; eb < 2; eb++)
          for (int ia = 0; ia < 2; ia++)
            for (int ci = 0; ci < 2; ci++)
              for (int av = 0; av < 16; av++)
                for (int bv = 0; bv < 16; bv++) begin
                  int ac, bc, s, er, ec, eo;
                  drive(av, bv, f, ea, eb, ia, ci);
                  ac = ea ? av : 0;
                  if (ia != 0) ac = (~ac) & 15;
                  bc = eb ? bv : 0;
                  ec = 0; eo = 0;
                  case (f)
                    0: er = ac & bc;
                    1: er = (~bc) & 15;
                    2: er = ac | bc;
                    default: begin
                      s  = ac + bc + ci;
                      er = s & 15;
                      ec = (s >> 4) & 1;
                      eo = (((ac >> 3) & 1) == ((bc >> 3) & 1)) &&
                           (((er >> 3) & 1) != ((ac >> 3) & 1)) ? 1 : 0;
                    end
                  endcase
                  case (f)
                    0: check("R1 and sweep",  pack(ovf, cout, res), er);
                    1: check("R2 notb sweep", pack(ovf, cout, res), er);
                    2: check("R3 or sweep",   pack(ovf, cout, res), er);
                    default: check("R4 add sweep", pack(ovf, cout, res), (eo << 5) | (ec << 4) | er);
                  endcase
                end

    // R5: A disabled then inverted reads as all ones through AND.
    drive(4'h5, 4'hA, 0, 0, 1, 1, 0);
    check("R5 gated A inverted", res, 4'hA);
    // R2: disabled B yields all ones.
    drive(4'h3, 4'h6, 1, 1, 0, 0, 0);
    check("R2 notb of disabled B", res, 4'hF);
    // R6: OR of all ones has no carry.
    drive(4'hF, 4'hF, 2, 1, 1, 0, 1);
    check("R6 cout idle in OR", cout, 0);
    // R7: subtraction B - A.
    drive(3, 9, 3, 1, 1, 1, 1);
    check("R7 9-3", res, 6);
    drive(9, 3, 3, 1, 1, 1, 1);
    check("R7 3-9", res, 4'hA);
    // R8: positive overflow in add, suppressed in OR.
    drive(7, 1, 3, 1, 1, 0, 0);
    check("R8 7+1 ovf", ovf, 1);
    drive(7, 1, 2, 1, 1, 0, 0);
    check("R8 no ovf in OR", ovf, 0);
    drive(4'h8, 4'h8, 3, 1, 1, 0, 0);
    check("R8 neg ovf", ovf, 1);
    // R9: wrap of 1111 + 0001.
    drive(4'hF, 4'h1, 3, 1, 1, 0, 0);
    check("R9 wrap result", res, 0);
    check("R9 wrap carry", cout, 1);

    // R10: 98 + 35 at 8 bits.
    @(posedge clk);
    a8 = 8'd98; b8 = 8'd35; fsel8 = 2'b11;
    @(negedge clk);
    check("R10 sum", res8, 8'b10000101);
    check("R10 ovf", ovf8, 1);
    check("R10 cout", cout8, 0);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule